// File: doc/BRIEF.md
# Protection Region Range Decoder

This block converts the settings of a bank of memory protection entries into explicit byte ranges. Each entry has a two-bit match mode and a raw address register. The raw address counts 4-byte words, so it is two bits narrower than a byte address. From the entry's mode, its own raw address and the raw address of the entry below it, the decoder computes an inclusive first and last byte address. It also flags the entry as active when its mode is not OFF, and it counts the active entries across the bank.

The decode is combinational per entry and is instantiated once for each entry. All results are captured into output registers when the update strobe is high, and they hold their values until the next strobe. A checker further along the pipeline can then compare an access address against plain start and end bounds, with no need to know the match modes. Permission evaluation and priority between overlapping entries belong to other blocks.

Top module: `region_range_decoder`

## Requirements
- R1: In the cycle after `rst` is high, every start, end, active and count output is zero.
- R2: Outputs take newly decoded values in the cycle after a clock edge at which `upd` is high. When `upd` is low, the outputs keep their values whatever the inputs do.
- R3: Mode code 0 (OFF) gives start 0, end 0 and active low.
- R4: Mode code 1 (top of range) gives start = previous raw address × 4 and end = (own raw address × 4) − 1, modulo 2^(ADDR_W+2). Entry 0 uses 0 as its previous raw address.
- R5: In mode code 1, when the computed start is greater than the computed end, both start and end are 0. Start never exceeds end for any decoded entry.
- R6: Mode code 2 (single aligned word) gives start = raw address × 4 and end = start + 3.
- R7: Mode code 3 (aligned power-of-two) covers 8 bytes when bit 0 of the raw address is 0, and the size doubles for each further trailing one. The region is aligned to its own size and contains raw address × 4. A raw address of all ones covers the whole byte space.
- R8: Active is high exactly when the mode code is not 0, and the count output equals the number of active entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd | input | 1 | Update strobe: capture newly decoded ranges |
| mode_i | input | 2*N_ENTRIES | Mode code of entry i at bits [2i+1:2i] |
| addr_i | input | ADDR_W*N_ENTRIES | Raw word address of entry i at bits [ADDR_W*i +: ADDR_W] |
| start_o | output | (ADDR_W+2)*N_ENTRIES | First byte of entry i's range, same packing |
| end_o | output | (ADDR_W+2)*N_ENTRIES | Last byte of entry i's range, same packing |
| active_o | output | N_ENTRIES | Entry i has a mode other than OFF |
| count_o | output | $clog2(N_ENTRIES+1) | Number of active entries |

## Verification
On every cycle, the assertions check that the outputs hold while the strobe is low and that each active flag follows the mode captured at the last strobe. They also check that the count agrees with the active flags, that no decoded range has its start above its end, and that reset clears the count. Whether the bounds are numerically right for each mode (the top-of-range subtraction and its collapse, the word decode, and the trailing-ones sizing of power-of-two regions) can only be shown by the bench. The bench sweeps every mode and address pair of a 4-bit configuration and compares each result with an arithmetic model.

// File: rtl/rrd_pkg.sv
package rrd_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_TOR   = 2'd1,
    MODE_NA4   = 2'd2,
    MODE_NAPOT = 2'd3
  } match_mode_e;
endpackage

// File: rtl/rrd_entry_decode.sv
module rrd_entry_decode
  import rrd_pkg::*;
#(
  parameter int ADDR_W = 8,
  localparam int BW = ADDR_W + 2
) (
  input  match_mode_e       mode,
  input  logic [ADDR_W-1:0] cur,
  input  logic [ADDR_W-1:0] prev,
  output logic [BW-1:0]     lo,
  output logic [BW-1:0]     hi,
  output logic              active
);
  logic [BW-1:0] cur_b, prev_b, tor_hi, pot, pot_inc;

  always_comb begin
    cur_b   = {cur, 2'b00};
    prev_b  = {prev, 2'b00};
    tor_hi  = cur_b - BW'(1);
    pot     = {cur, 2'b11};
    pot_inc = pot + BW'(1);
    active  = (mode != MODE_OFF);
    lo      = '0;
    hi      = '0;
    unique case (mode)
      MODE_OFF: begin
        lo = '0;
        hi = '0;
      end
      MODE_TOR: begin
        if (prev_b > tor_hi) begin
          lo = '0;
          hi = '0;
        end else begin
          lo = prev_b;
          hi = tor_hi;
        end
      end
      MODE_NA4: begin
        lo = cur_b;
        hi = cur_b | BW'(3);
      end
      MODE_NAPOT: begin
        lo = pot & pot_inc;
        hi = pot | pot_inc;
      end
      default: begin
        lo = '0;
        hi = '0;
      end
    endcase
  end
endmodule

// File: rtl/rrd_count.sv
module rrd_count #(
  parameter int N  = 4,
  localparam int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  act,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < N; i++) begin
      cnt = cnt + CW'(act[i]);
    end
  end
endmodule

// File: rtl/region_range_decoder.sv
module region_range_decoder
  import rrd_pkg::*;
#(
  parameter int N_ENTRIES = 4,
  parameter int ADDR_W    = 8,
  localparam int BW = ADDR_W + 2,
  localparam int CW = $clog2(N_ENTRIES + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      upd,
  input  logic [2*N_ENTRIES-1:0]    mode_i,
  input  logic [ADDR_W*N_ENTRIES-1:0] addr_i,
  output logic [BW*N_ENTRIES-1:0]   start_o,
  output logic [BW*N_ENTRIES-1:0]   end_o,
  output logic [N_ENTRIES-1:0]      active_o,
  output logic [CW-1:0]             count_o
);
  logic [BW*N_ENTRIES-1:0] lo_d, hi_d;
  logic [N_ENTRIES-1:0]    act_d;
  logic [CW-1:0]           cnt_d;

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_entry
    logic [ADDR_W-1:0] prev_addr;
    if (g == 0) begin : g_first
      assign prev_addr = '0;
    end else begin : g_rest
      assign prev_addr = addr_i[ADDR_W*(g-1) +: ADDR_W];
    end

    rrd_entry_decode #(.ADDR_W(ADDR_W)) i_dec (
      .mode   (match_mode_e'(mode_i[2*g +: 2])),
      .cur    (addr_i[ADDR_W*g +: ADDR_W]),
      .prev   (prev_addr),
      .lo     (lo_d[BW*g +: BW]),
      .hi     (hi_d[BW*g +: BW]),
      .active (act_d[g])
    );

    // R8: flag follows the mode captured at the last strobe
    p_active_r8: assert property (@(posedge clk) disable iff (rst)
      upd |=> (active_o[g] == ($past(mode_i[2*g +: 2]) != 2'd0)));

    // R5: no decoded range is inverted
    p_order_r5: assert property (@(posedge clk) disable iff (rst)
      start_o[BW*g +: BW] <= end_o[BW*g +: BW]);
  end

  rrd_count #(.N(N_ENTRIES)) i_cnt (
    .act (act_d),
    .cnt (cnt_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      start_o  <= '0;
      end_o    <= '0;
      active_o <= '0;
      count_o  <= '0;
    end else if (upd) begin
      start_o  <= lo_d;
      end_o    <= hi_d;
      active_o <= act_d;
      count_o  <= cnt_d;
    end
  end

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (count_o == '0 && active_o == '0));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !upd |=> ($stable(start_o) && $stable(end_o) && $stable(active_o)));

  p_count_r8: assert property (@(posedge clk) disable iff (rst)
    count_o == CW'($countones(active_o)));
endmodule

// File: tb/test_region_range_decoder.sv
`timescale 1ns/1ps
module test_region_range_decoder;
  localparam int N  = 4;
  localparam int AW = 4;
  localparam int BW = AW + 2;
  localparam int CW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic upd = 1'b0;
  logic [2*N-1:0]  mode_i = '0;
  logic [AW*N-1:0] addr_i = '0;
  logic [BW*N-1:0] start_o, end_o;
  logic [N-1:0]    active_o;
  logic [CW-1:0]   count_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  region_range_decoder #(.N_ENTRIES(N), .ADDR_W(AW)) i_region_range_decoder (
    .clk(clk), .rst(rst), .upd(upd), .mode_i(mode_i), .addr_i(addr_i),
    .start_o(start_o), .end_o(end_o), .active_o(active_o), .count_o(count_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected {start,end} and requirement tag from the arithmetic model
  task automatic model(input int m, input int cur, input int prev,
                       output int s, output int e, output string tag);
    int k, size;
    s = 0; e = 0; tag = "R3";
    case (m)
      1: begin
        s = prev * 4;
        e = (cur * 4 + (1 << BW) - 1) % (1 << BW);
        tag = "R4";
        if (s > e) begin s = 0; e = 0; tag = "R5"; end
      end
      2: begin s = cur * 4; e = s + 3; tag = "R6"; end
      3: begin
        tag = "R7";
        k = 0;
        while (k < AW && ((cur >> k) & 1) == 1) k++;
        if (k == AW) begin s = 0; e = (1 << BW) - 1; end
        else begin
          size = 8 << k;
          s = (cur * 4) - ((cur * 4) % size);
          e = s + size - 1;
        end
      end
      default: ;
    endcase
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int md[N];
    int ad[N];
    int s, e, cnt;
    string tag;
    logic [BW*N-1:0] hs, he;
    logic [N-1:0] ha;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1", int'(start_o), 0);
    chk("R1", int'(end_o), 0);
    chk("R1", int'(active_o), 0);
    chk("R1", int'(count_o), 0);

    for (int m = 0; m < 4; m++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          md[0] = m;           ad[0] = a;
          md[1] = m;           ad[1] = b;
          md[2] = (m + 1) % 4; ad[2] = a ^ b;
          md[3] = (m + 2) % 4; ad[3] = (a + b) % 16;
          for (int i = 0; i < N; i++) begin
            mode_i[2*i +: 2]  = 2'(md[i]);
            addr_i[AW*i +: AW] = AW'(ad[i]);
          end
          upd = 1'b1;
          @(negedge clk);
          upd = 1'b0;
          cnt = 0;
          for (int i = 0; i < N; i++) begin
            model(md[i], ad[i], (i == 0) ? 0 : ad[i-1], s, e, tag);
            chk(tag, int'(start_o[BW*i +: BW]), s);
            chk(tag, int'(end_o[BW*i +: BW]), e);
            chk("R8", int'(active_o[i]), (md[i] != 0) ? 1 : 0);
            if (md[i] != 0) cnt++;
          end
          chk("R8", int'(count_o), cnt);
          // R2: inputs change without strobe, outputs must hold
          hs = start_o; he = end_o; ha = active_o;
          mode_i = ~mode_i;
          addr_i = ~addr_i;
          @(negedge clk);
          chk("R2", int'(start_o != hs), 0);
          chk("R2", int'(end_o != he), 0);
          chk("R2", int'(active_o != ha), 0);
        end
      end
    end

    // R1: reset clears previously loaded state
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1", int'(end_o), 0);
    chk("R1", int'(count_o), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule